// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of a pulse-width modulator. A free-running prescaler divides the system clock down to a time-base tick. On each tick a 16-bit counter steps according to the selected counting mode: it can count up, count down, count up then down, or hold still. Compare and action logic placed beside it uses the counter value, the zero and period event pulses and the count direction to shape PWM waveforms.

Software sets the block up with two 16-bit registers on a plain write port. One is a control register that holds the mode, the period load policy and the two prescaler fields. The other is the period register. A period write either takes effect at once or goes to a shadow copy that moves into the active period the next time the counter passes zero. That second path lets a running waveform change its period without a glitched cycle.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the mode is frozen (control value 0x0003), the active and shadow periods are 0xFFFF, the direction output is 0 (up) and neither event output is asserted.
- R2: A write to byte address 0x00 loads the control register, which takes effect from the next clock. In that register, bits 1:0 select the mode (00 up, 01 down, 10 up-down, 11 frozen), bit 3 selects the period load policy, bits 9:7 form the fine divider field F and bits 12:10 form the coarse divider field C. A write to byte address 0x0A is a period write.
- R3: Up mode: on each tick the counter increments, and if it is at or above the active period it goes to 0 instead.
- R4: Down mode: on each tick the counter decrements, and if it is at 0 it reloads the active period instead.
- R5: Up-down mode: the counter rises to the active period, reverses, falls to 0, and reverses again. It does not repeat a value at either turning point, and a period of 0 keeps it at 0.
- R6: Frozen mode: the counter and the direction output hold their values.
- R7: The tick occurs once every N system clocks, where N = (F == 0 ? 1 : 2·F) · 2^C. The counter changes only in a clock that has a tick. The prescaler runs in every mode.
- R8: Shadow policy (bit 3 = 0): a period write updates only the shadow. The shadow is copied into the active period on the clock edge that ends a zero event.
- R9: Immediate policy (bit 3 = 1): a period write updates the active and shadow periods together on that edge. No copy happens at zero.
- R10: The zero event output is high for exactly the clock that holds a tick while the counter is 0 and the mode is not frozen. The period event output behaves the same way for a counter equal to the active period.
- R11: The direction output is 1 while counting down. On a tick it becomes 0 in up mode and 1 in down mode, and in up-down mode it follows the reversals.
- R12: Writes to any address other than 0x00 and 0x0A change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 16 | Write data |
| tb_count | output | 16 | Current time-base counter value |
| tb_zero | output | 1 | Counter-equals-zero event pulse |
| tb_period | output | 1 | Counter-equals-period event pulse |
| tb_dir_down | output | 1 | 1 while counting down |

## Verification
The bench targets the turning points. In up-down mode a design that repeats the period value or zero would stretch each cycle by two ticks. In up mode a design that misses the wrap when the period shrinks below the counter would run all the way around 16 bits. The bench also writes a shadow period in the same clock as a zero event. A design that copies the new value there, or that copies at zero under the immediate policy, puts the wrong period in use for a whole cycle. Prescale ratios are changed mid-count to expose a divider that only tests for exact equality and so misses its terminal count.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
   typedef enum logic [1:0] {
      MODE_UP   = 2'b00,
      MODE_DOWN = 2'b01,
      MODE_UPDN = 2'b10,
      MODE_HOLD = 2'b11
   } tb_mode_e;

   localparam int CTRL_MODE_LSB = 0;
   localparam int CTRL_LOAD_BIT = 3;
   localparam int CTRL_FINE_LSB = 7;
   localparam int CTRL_CRS_LSB  = 10;
endpackage

// File: rtl/pwm_timebase_regs.sv
module pwm_timebase_regs
   import pwm_timebase_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 8,
   parameter int CTRL_ADDR = 0,
   parameter int PRD_ADDR  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              zero_evt,
   output logic [15:0]       ctrl_q,
   output logic [CNT_W-1:0]  prd_act_q
);
   logic [CNT_W-1:0] prd_shd_q;
   logic             ctrl_we, prd_we, imm_load;

   assign ctrl_we  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
   assign prd_we   = wr_en && (wr_addr == ADDR_W'(PRD_ADDR));
   assign imm_load = ctrl_q[CTRL_LOAD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= 16'h0003;
         prd_act_q <= '1;
         prd_shd_q <= '1;
      end else begin
         if (ctrl_we)
            ctrl_q <= wr_data;
         if (prd_we)
            prd_shd_q <= wr_data[CNT_W-1:0];
         if (prd_we && imm_load)
            prd_act_q <= wr_data[CNT_W-1:0];
         else if (zero_evt && !imm_load)
            prd_act_q <= prd_shd_q;
      end
   end

   // R9: immediate policy lands the written period on the next edge
   a_r9_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
      (prd_we && imm_load) |=> (prd_act_q == $past(wr_data[CNT_W-1:0])));
   // R8: shadow policy leaves the active period alone outside zero events
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!imm_load && !zero_evt) |=> $stable(prd_act_q));
endmodule

// File: rtl/pwm_timebase_prescale.sv
module pwm_timebase_prescale #(
   parameter int FIELD_W   = 3,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] fine_div,
   input  logic [FIELD_W-1:0] coarse_div,
   output logic               tick
);
   localparam int FINE_MAX  = (1 << FIELD_W) - 1;
   localparam int RATIO_MAX = 2 * FINE_MAX * (1 << FINE_MAX);
   localparam int PS_W      = $clog2(RATIO_MAX + 1);

   generate
      if (FIELD_W < 1 || FIELD_W > 4) begin : g_bad_field
         $error("pwm_timebase_prescale: FIELD_W out of range");
      end
      if (PRESCALE_EN) begin : g_div
         logic [PS_W-1:0] ratio, pcnt_q;
         logic [PS_W-1:0] fine_mult;

         assign fine_mult = (fine_div == '0) ? PS_W'(1) : PS_W'({fine_div, 1'b0});
         assign ratio     = fine_mult << coarse_div;
         assign tick      = (pcnt_q >= ratio - PS_W'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pcnt_q <= '0;
            else if (tick)
               pcnt_q <= '0;
            else
               pcnt_q <= pcnt_q + PS_W'(1);
         end

         // R7: the divider restarts right after its terminal count
         a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (pcnt_q == '0));
      end else begin : g_nodiv
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pwm_timebase_counter.sv
module pwm_timebase_counter
   import pwm_timebase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tb_mode_e         mode,
   input  logic [CNT_W-1:0] prd,
   output logic [CNT_W-1:0] cnt_q,
   output logic             dir_q,
   output logic             zero_evt,
   output logic             prd_evt
);
   logic [CNT_W-1:0] cnt_d;
   logic             dir_d, at_zero, at_top;

   assign at_zero  = (cnt_q == '0);
   assign at_top   = (cnt_q >= prd);
   assign zero_evt = tick && at_zero && (mode != MODE_HOLD);
   assign prd_evt  = tick && (cnt_q == prd) && (mode != MODE_HOLD);

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      unique case (mode)
         MODE_UP: begin
            dir_d = 1'b0;
            cnt_d = at_top ? '0 : cnt_q + CNT_W'(1);
         end
         MODE_DOWN: begin
            dir_d = 1'b1;
            cnt_d = at_zero ? prd : cnt_q - CNT_W'(1);
         end
         MODE_UPDN: begin
            if (!dir_q) begin
               if (at_top) begin
                  dir_d = 1'b1;
                  cnt_d = at_zero ? '0 : cnt_q - CNT_W'(1);
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end else begin
               if (at_zero) begin
                  dir_d = 1'b0;
                  cnt_d = (prd == '0) ? '0 : CNT_W'(1);
               end else begin
                  cnt_d = cnt_q - CNT_W'(1);
               end
            end
         end
         default: begin
            cnt_d = cnt_q;
            dir_d = dir_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   // R6: frozen mode holds the counter
   a_r6_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOLD) |=> $stable(cnt_q));
   // R7: no counter step without a tick
   a_r7_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
   // R3: up mode below the period increments by one
   a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UP && cnt_q < prd) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   // R11: down mode reports the down direction
   a_r11_down_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_DOWN) |=> dir_q);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_timebase_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 8,
   parameter int FIELD_W   = 3,
   parameter int CTRL_ADDR = 0,
   parameter int PRD_ADDR  = 10,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   output logic [CNT_W-1:0]  tb_count,
   output logic              tb_zero,
   output logic              tb_period,
   output logic              tb_dir_down
);
   logic [15:0]        ctrl;
   logic [CNT_W-1:0]   prd_act;
   logic               tick, zero_evt, prd_evt;
   tb_mode_e           mode;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
         $error("pwm_timebase: CNT_W must be 2..16");
      end
      if (CTRL_ADDR == PRD_ADDR) begin : g_bad_addr
         $error("pwm_timebase: register addresses collide");
      end
   endgenerate

   assign mode = tb_mode_e'(ctrl[CTRL_MODE_LSB +: 2]);

   pwm_timebase_regs #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .PRD_ADDR(PRD_ADDR)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .zero_evt(zero_evt), .ctrl_q(ctrl), .prd_act_q(prd_act)
   );

   pwm_timebase_prescale #(
      .FIELD_W(FIELD_W), .PRESCALE_EN(PRESCALE_EN)
   ) pres_i (
      .clk(clk), .rst_n(rst_n),
      .fine_div(ctrl[CTRL_FINE_LSB +: FIELD_W]),
      .coarse_div(ctrl[CTRL_CRS_LSB +: FIELD_W]),
      .tick(tick)
   );

   pwm_timebase_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .prd(prd_act),
      .cnt_q(tb_count), .dir_q(tb_dir_down), .zero_evt(zero_evt), .prd_evt(prd_evt)
   );

   assign tb_zero   = zero_evt;
   assign tb_period = prd_evt;

   // R10: a zero event needs a zero count
   a_r10_zero_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tb_zero |-> (tb_count == '0));
endmodule

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SEED = 1234;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] tb_count;
   logic        tb_zero, tb_period, tb_dir_down;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string phase_tag = "R1";

   // bench reference state
   logic [15:0] m_ctrl, m_act, m_shd, m_cnt;
   logic        m_dir;
   int          m_pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_timebase dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tb_count(tb_count), .tb_zero(tb_zero), .tb_period(tb_period),
      .tb_dir_down(tb_dir_down)
   );

   function automatic int ratio_of(logic [15:0] c);
      int f = c[9:7];
      int k = c[12:10];
      return ((f == 0) ? 1 : 2 * f) << k;
   endfunction

   function automatic bit m_tick();
      return m_pc >= ratio_of(m_ctrl) - 1;
   endfunction

   function automatic bit m_zero();
      return m_tick() && m_cnt == 16'd0 && m_ctrl[1:0] != 2'b11;
   endfunction

   function automatic bit m_prd();
      return m_tick() && m_cnt == m_act && m_ctrl[1:0] != 2'b11;
   endfunction

   task automatic m_reset();
      m_ctrl = 16'h0003; m_act = 16'hFFFF; m_shd = 16'hFFFF;
      m_cnt = 0; m_dir = 0; m_pc = 0;
   endtask

   task automatic check(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(phase_tag, "count", tb_count, m_cnt);
      check("R10", "zero event", tb_zero, m_zero());
      check("R10", "period event", tb_period, m_prd());
      check("R11", "direction", tb_dir_down, m_dir);
   endtask

   // advance reference by one edge using the inputs now driven
   task automatic m_step();
      bit t = m_tick();
      bit z = m_zero();
      logic [15:0] nc = m_cnt;
      logic nd = m_dir;
      logic [15:0] oc = m_ctrl;
      if (t) begin
         case (oc[1:0])
            2'b00: begin nd = 0; nc = (m_cnt >= m_act) ? 16'd0 : m_cnt + 16'd1; end
            2'b01: begin nd = 1; nc = (m_cnt == 0) ? m_act : m_cnt - 16'd1; end
            2'b10: begin
               if (!m_dir) begin
                  if (m_cnt >= m_act) begin nd = 1; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
                  else nc = m_cnt + 16'd1;
               end else begin
                  if (m_cnt == 0) begin nd = 0; nc = (m_act == 0) ? 16'd0 : 16'd1; end
                  else nc = m_cnt - 16'd1;
               end
            end
            default: ;
         endcase
      end
      m_pc = t ? 0 : m_pc + 1;
      if (wr_en && wr_addr == 8'h0A) begin
         if (oc[3]) m_act = wr_data;
         else if (z) m_act = m_shd;
         m_shd = wr_data;
      end else if (z && !oc[3]) begin
         m_act = m_shd;
      end
      if (wr_en && wr_addr == 8'h00) m_ctrl = wr_data;
      m_cnt = nc;
      m_dir = nd;
   endtask

   // one clock: compare at negedge, drive, update model
   task automatic cycle(bit we, logic [7:0] a, logic [15:0] d);
      @(negedge clk);
      compare_all();
      wr_en = we; wr_addr = a; wr_data = d;
      m_step();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle(0, 8'h00, 16'h0000);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(SEED));
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      phase_tag = "R1";
      check("R1", "reset count", tb_count, 0);
      check("R1", "reset zero evt", tb_zero, 0);
      check("R1", "reset dir", tb_dir_down, 0);
      rst_n = 1'b1;
      idle(6);

      // R2 + R9: immediate policy, short period, up mode
      phase_tag = "R9";
      cycle(1, 8'h00, 16'h000B);
      cycle(1, 8'h0A, 16'd5);
      cycle(1, 8'h00, 16'h0008);
      phase_tag = "R3";
      idle(20);
      // R3: shrink period below counter, must wrap instead of run away
      cycle(1, 8'h0A, 16'd2);
      idle(10);
      // R4: down mode
      phase_tag = "R4";
      cycle(1, 8'h00, 16'h0009);
      idle(15);
      // R5: up-down mode
      phase_tag = "R5";
      cycle(1, 8'h0A, 16'd4);
      cycle(1, 8'h00, 16'h000A);
      idle(24);
      // R5: period zero keeps counter at zero
      cycle(1, 8'h0A, 16'd0);
      idle(8);
      cycle(1, 8'h0A, 16'd3);
      idle(6);
      // R6: frozen
      phase_tag = "R6";
      cycle(1, 8'h00, 16'h000B);
      idle(10);
      // R7: prescale 4 and 12, changed mid count
      phase_tag = "R7";
      cycle(1, 8'h00, 16'h0488);
      idle(40);
      cycle(1, 8'h00, 16'h0588);
      idle(60);
      cycle(1, 8'h00, 16'h0008);
      idle(5);
      // R8: shadow policy, up mode, period 6; new period only at zero
      phase_tag = "R8";
      cycle(1, 8'h0A, 16'd6);
      cycle(1, 8'h00, 16'h0000);
      idle(3);
      cycle(1, 8'h0A, 16'd3);
      idle(12);
      for (int i = 0; i < 40; i++) begin
         if (m_zero()) begin
            @(negedge clk); compare_all();
            wr_en = 1; wr_addr = 8'h0A; wr_data = 16'd9; m_step();
            break;
         end
         cycle(0, 8'h00, 16'h0000);
      end
      idle(25);
      // R12: other addresses ignored
      phase_tag = "R12";
      cycle(1, 8'h02, 16'h0003);
      cycle(1, 8'h0B, 16'd1);
      cycle(1, 8'h14, 16'h0001);
      idle(20);

      // random phase
      phase_tag = "R2";
      for (int i = 0; i < 4000; i++) begin
         int r = $urandom_range(0, 99);
         if (r < 3) begin
            logic [15:0] c = 16'h0;
            c[1:0]   = 2'($urandom_range(0, 3));
            c[3]     = 1'($urandom_range(0, 1));
            c[9:7]   = 3'($urandom_range(0, 2));
            c[12:10] = 3'($urandom_range(0, 1));
            cycle(1, 8'h00, c);
         end else if (r < 7) begin
            cycle(1, 8'h0A, 16'($urandom_range(0, 12)));
         end else if (r < 9) begin
            cycle(1, 8'($urandom_range(1, 9)), 16'($urandom));
         end else begin
            cycle(0, 8'h00, 16'h0000);
         end
      end
      @(negedge clk);
      compare_all();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule